// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This block turns a 16-bit segment selector into a decoded segment. It keeps a base and a limit for two descriptor tables, a global one and a local one. Selector bit 2 chooses the table. The low three selector bits are cleared to give the byte offset of an 8-byte descriptor inside that table. The offset is checked against the table limit before anything goes to memory. If the whole descriptor fits, the block reads two 32-bit words over a simple read-only memory port. It then presents both raw words, the 32-bit segment base and the segment limit. The limit is scaled to 4 KiB units when the descriptor's granularity flag is set.

A client offers a selector with a valid strobe. The block takes it only while idle, which it shows on a ready output. Completion is marked by a one-cycle done strobe. A fault flag accompanies the strobe and tells a bounds violation apart from a good fetch. Table bases and limits are loaded through a write port at any time. A lookup uses the values held in the cycle it is accepted.

Top module: `seg_desc_fetch`

## Requirements
- R1: Selector bit 2 set uses the local table base and limit; bit 2 clear uses the global table base and limit.
- R2: The descriptor byte offset is the selector with bits 2:0 forced to zero. The first read address is the chosen table base plus that offset, modulo 2^32.
- R3: When offset + 7 is greater than the chosen table limit, the block raises done and fault in the cycle after acceptance and issues no memory request for that lookup.
- R4: A good lookup issues exactly two reads, the second at the first address plus 4. `mem_req` is high for one cycle per read, and a new read is never issued before `mem_rvalid` has returned the previous one.
- R5: The segment limit is {word2[19:16], word1[15:0]}, zero-extended. When word2 bit 23 (granularity) is 1, the limit is that value shifted left by 12 with the low 12 bits set to 1.
- R6: The segment base is {word2[31:24], word2[7:0], word1[31:16]}. `desc_lo` and `desc_hi` hold the first and second words read.
- R7: A good lookup pulses done for one cycle with fault low, in the cycle after the second `mem_rvalid`.
- R8: `sel_ready` is high only while idle. A selector offered while busy is ignored and does not change the lookup in progress.
- R9: After reset `sel_ready` is 1, `mem_req` and `done` are 0, and both table limits and bases are 0, so any lookup faults until a table is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write a table base and limit |
| cfg_local | input | 1 | Target of the write: 1 local table, 0 global table |
| cfg_base | input | 32 | Table base to write |
| cfg_limit | input | TLIM_W | Table limit to write |
| sel_valid | input | 1 | Selector offered |
| selector | input | 16 | Segment selector |
| sel_ready | output | 1 | Idle, selector will be taken |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Lookup finished (one cycle) |
| fault | output | 1 | With done: bounds violation |
| desc_lo | output | 32 | First descriptor word |
| desc_hi | output | 32 | Second descriptor word |
| seg_base | output | 32 | Decoded segment base |
| seg_limit | output | 32 | Decoded, granularity-expanded limit |

## Verification
The hardest cases to reach from the ports are the limit edges. The last descriptor that still fits must pass, and the next one must fault. The same holds for a table limit that does not end in binary 111, where a descriptor that starts inside the table still runs past its end. The bench sweeps every table index across both tables under two table configurations. One configuration has limits ending in 7 and the other has limits one short of that. This puts the fault boundary on both sides of an 8-byte edge. A base near the top of the address space forces the address sum to wrap. The memory model varies its latency from lookup to lookup. During each busy period it also offers a conflicting selector, to show that the lookup in flight is not disturbed.

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch #(
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_local,
  input  logic [31:0]       cfg_base,
  input  logic [TLIM_W-1:0] cfg_limit,
  input  logic              sel_valid,
  input  logic [15:0]       selector,
  output logic              sel_ready,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [31:0]       desc_lo,
  output logic [31:0]       desc_hi,
  output logic [31:0]       seg_base,
  output logic [31:0]       seg_limit
);
  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1} state_t;

  state_t            state;
  logic [31:0]       gbase, lbase, addr_q;
  logic [TLIM_W-1:0] glim, llim;

  wire               use_local = selector[2];
  wire [15:0]        offset    = {selector[15:3], 3'b000};
  wire [31:0]        tbase     = use_local ? lbase : gbase;
  wire [TLIM_W-1:0]  tlim      = use_local ? llim : glim;
  wire [31:0]        last_byte = 32'(offset) + 32'd7;
  wire               out_of_bounds = last_byte > 32'(tlim);
  wire               accept    = sel_valid && (state == S_IDLE);

  assign sel_ready = (state == S_IDLE);
  assign mem_req   = (state == S_REQ0) || (state == S_REQ1);
  assign mem_addr  = addr_q;

  wire [19:0] raw_limit = {desc_hi[19:16], desc_lo[15:0]};
  assign seg_limit = desc_hi[23] ? {raw_limit, 12'hFFF} : {12'h000, raw_limit};
  assign seg_base  = {desc_hi[31:24], desc_hi[7:0], desc_lo[31:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbase <= '0;
      lbase <= '0;
      glim  <= '0;
      llim  <= '0;
    end else if (cfg_we) begin
      if (cfg_local) begin
        lbase <= cfg_base;
        llim  <= cfg_limit;
      end else begin
        gbase <= cfg_base;
        glim  <= cfg_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
      desc_lo <= '0;
      desc_hi <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (accept) begin
            if (out_of_bounds) begin
              done  <= 1'b1;
              fault <= 1'b1;
            end else begin
              addr_q <= tbase + 32'(offset);
              state  <= S_REQ0;
            end
          end
        S_REQ0: state <= S_WAIT0;
        S_WAIT0:
          if (mem_rvalid) begin
            desc_lo <= mem_rdata;
            addr_q  <= addr_q + 32'd4;
            state   <= S_REQ1;
          end
        S_REQ1: state <= S_WAIT1;
        S_WAIT1:
          if (mem_rvalid) begin
            desc_hi <= mem_rdata;
            done    <= 1'b1;
            fault   <= 1'b0;
            state   <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fault_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_of_bounds) |=> (done && fault && !mem_req));

  assert_fetch_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !out_of_bounds) |=> (mem_req && !sel_ready && mem_addr == $past(tbase) + {16'h0, $past(selector) & 16'hFFF8}));

  assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_done_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> $past(mem_rvalid));

  assert_gran_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && desc_hi[23]) |-> (seg_limit[11:0] == 12'hFFF));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !sel_ready);
endmodule

// File: tb/seg_desc_fetch_test.sv
module seg_desc_fetch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_local = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_limit = '0;
  logic        sel_valid = 1'b0;
  logic [15:0] selector = '0;
  logic        sel_ready, mem_req, done, fault;
  logic [31:0] mem_addr, desc_lo, desc_hi, seg_base, seg_limit;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_desc_fetch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_local(cfg_local),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .sel_valid(sel_valid),
    .selector(selector), .sel_ready(sel_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .desc_lo(desc_lo), .desc_hi(desc_hi),
    .seg_base(seg_base), .seg_limit(seg_limit));

  function automatic logic [31:0] memword(logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ (a >> 3) ^ 32'h5A5A_C3C3;
  endfunction

  // memory model: latency set by the bench, counts requests and overlaps
  int          lat = 0, nreq = 0, overlap = 0, cnt = 0;
  bit          pend = 0;
  logic [31:0] paddr = '0;
  logic [31:0] addr_log [4];
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 0;
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= memword(paddr);
          pend <= 0;
        end else cnt <= cnt - 1;
      end
      if (mem_req) begin
        if (pend && cnt != 0) overlap <= overlap + 1;
        pend <= 1;
        paddr <= mem_addr;
        cnt <= lat;
        addr_log[nreq % 4] <= mem_addr;
        nreq <= nreq + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] gb, lb;
  logic [15:0] gl, ll;

  task automatic set_table(bit loc, logic [31:0] b, logic [15:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_local = loc; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_we = 1'b0;
    if (loc) begin lb = b; ll = l; end else begin gb = b; gl = l; end
  endtask

  task automatic lookup(logic [15:0] sel);
    logic [15:0] off;
    logic [31:0] a0, w0, w1, eb, el, lastb, tb;
    logic [15:0] tl;
    bit efault;
    int n0, waitc;
    off = sel & 16'hFFF8;
    tb = sel[2] ? lb : gb;
    tl = sel[2] ? ll : gl;
    lastb = {16'h0, off} + 32'd7;
    efault = lastb > {16'h0, tl};
    a0 = tb + {16'h0, off};
    w0 = memword(a0);
    w1 = memword(a0 + 32'd4);
    el = (w0 & 32'h0000_FFFF) | (w1 & 32'h000F_0000);
    if (w1[23]) el = (el << 12) | 32'hFFF;
    eb = (w0 >> 16) | ((w1 & 32'hFF) << 16) | (w1 & 32'hFF00_0000);

    @(negedge clk);
    n0 = nreq;
    sel_valid = 1'b1; selector = sel;
    @(negedge clk);
    if (efault) begin
      sel_valid = 1'b0;
      chk(done && fault, "R3 fault strobe", {30'h0, done, fault}, 32'h3);
      chk(nreq == n0, "R3 no access", nreq - n0, 0);
      return;
    end
    // busy: offer a conflicting selector that must be ignored
    selector = sel ^ 16'h0004;
    chk(!sel_ready, "R8 busy not ready", {31'h0, sel_ready}, 0);
    @(negedge clk);
    chk(!sel_ready, "R8 busy not ready", {31'h0, sel_ready}, 0);
    sel_valid = 1'b0;
    waitc = 0;
    while (!done && waitc < 50) begin @(negedge clk); waitc++; end
    chk(done && !fault, "R7 done without fault", {30'h0, done, fault}, 32'h2);
    chk(nreq - n0 == 2, "R4 two reads", nreq - n0, 2);
    chk(addr_log[n0 % 4] == a0, "R1 R2 first address", addr_log[n0 % 4], a0);
    chk(addr_log[(n0 + 1) % 4] == a0 + 32'd4, "R4 second address", addr_log[(n0 + 1) % 4], a0 + 32'd4);
    chk(desc_lo == w0 && desc_hi == w1, "R6 raw words", desc_hi, w1);
    chk(seg_base == eb, "R6 base", seg_base, eb);
    chk(seg_limit == el, "R5 limit", seg_limit, el);
    @(negedge clk);
    chk(!done, "R7 single pulse", {31'h0, done}, 0);
  endtask

  initial begin
    gb = '0; lb = '0; gl = '0; ll = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_ready && !mem_req && !done, "R9 reset state",
        {29'h0, sel_ready, mem_req, done}, 32'h4);
    lookup(16'h0000);
    lookup(16'h0004);

    // config A: limits end in binary 111
    set_table(0, 32'h0000_1000, 16'h003F);
    set_table(1, 32'h8000_0200, 16'h001F);
    for (int ti = 0; ti < 2; ti++)
      for (int idx = 0; idx < 12; idx++) begin
        lat = (idx + ti) % 3;
        lookup(16'((idx << 3) | (ti << 2) | (idx % 4)));
      end

    // config B: limits one short, base that wraps
    set_table(0, 32'hFFFF_FFE0, 16'h003E);
    set_table(1, 32'h0004_0000, 16'h001E);
    for (int ti = 0; ti < 2; ti++)
      for (int idx = 0; idx < 10; idx++) begin
        lat = idx % 3;
        lookup(16'((idx << 3) | (ti << 2) | 3));
      end

    // full-range table, highest selector
    set_table(1, 32'h0010_0000, 16'hFFFF);
    lat = 2;
    lookup(16'hFFFC);
    lookup(16'hFFF8);

    chk(overlap == 0, "R4 one outstanding", overlap, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule